// File: doc/BRIEF.md
# Tick Compare Timer

This block holds a 64-bit compare register and watches a free-running 63-bit tick count supplied from outside. The top bit of the register disables the timer. The lower 63 bits hold the tick value at which a match should fire. Software writes the register through a simple write strobe, and the whole register can be read back at any time.

Each write decides on the spot whether the new target should be armed. Arming happens only when the disable bit is clear and the target lies strictly ahead of the count seen in the write cycle. Once the count reaches or passes an armed target, the block raises a single match pulse. That pulse is meant to set the tick-match bit of a soft-interrupt register. The block then disarms until the next write.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, the read port returns 0x8000_0000_0000_0000 (disable bit set, compare value zero) and the match pulse is low.
- R2: From the cycle after a write, the read port returns all 64 written bits unchanged.
- R3: A write with bit 63 set produces no match pulse, and it cancels any target that an earlier write armed.
- R4: A write with bit 63 clear arms the timer only when its low 63 bits, taken as an unsigned value, are strictly greater than the tick count in the write cycle. A target equal to or below that count never fires.
- R5: While armed, the first clock edge at which the tick count is greater than or equal to the target raises the match pulse for exactly one cycle, starting in the following cycle. The timer is then disarmed, so later counts give no further pulses.
- R6: A new write replaces any armed target. An old target that the count passes after the rewrite fires no pulse; only the new target can fire.
- R7: A write in the same cycle in which an armed target is reached takes priority. No pulse comes from the old target, and the outcome follows R3 and R4 for the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the compare register |
| wrData | input | 64 | Write value; bit 63 disables, bits 62:0 are the target |
| tickCount | input | 63 | Free-running tick count |
| rdData | output | 64 | Current compare register contents |
| matchPulse | output | 1 | One-cycle match pulse |

## Verification
Every result of this block is registered exactly once. The write value shows on the read port one cycle after the write edge. The match pulse is high in the cycle after the edge at which the count first meets an armed target. The bench applies its inputs between edges and samples both outputs one nanosecond after each rising edge. It holds them against a per-edge reference model that updates with the same inputs that edge consumed, so every expected value lines up with the cycle in which it is due. Directed cases place targets at the count, just behind it, just ahead of it, and colliding with a write. Seeded random writes and count jumps then cover the mixed cases.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReg;
  } tcStrobe_t;

  // datapath observations handed to control
  typedef struct packed {
    logic newDisable;
    logic newInFuture;
    logic reached;
  } tcStatus_t;

endpackage

// File: rtl/tick_cmp_dp.sv
module tick_cmp_dp
  import tick_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-2:0] tickCount,
  output logic [DATA_W-1:0] rdData,
  output tcStatus_t         stat
);
  localparam int CNT_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] RESET_VAL = {1'b1, {CNT_W{1'b0}}};

  logic [DATA_W-1:0] cmpRegQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpRegQ <= RESET_VAL;
    end else if (strobe.loadReg) begin
      cmpRegQ <= wrData;
    end
  end

  assign rdData = cmpRegQ;

  always_comb begin
    stat.newDisable  = wrData[DATA_W-1];
    stat.newInFuture = wrData[CNT_W-1:0] > tickCount;
    stat.reached     = tickCount >= cmpRegQ[CNT_W-1:0];
  end

  AST_READBACK_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadReg |=> rdData == $past(wrData)); // R2

endmodule

// File: rtl/tick_cmp_ctrl.sv
module tick_cmp_ctrl
  import tick_cmp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  tcStatus_t stat,
  output tcStrobe_t strobe,
  output logic      matchPulse
);
  logic armedQ;
  logic pulseQ;
  logic armOnWrite;
  logic hitNow;

  assign armOnWrite    = !stat.newDisable && stat.newInFuture;
  assign hitNow        = armedQ && stat.reached;
  assign strobe.loadReg = wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      pulseQ <= 1'b0;
    end else if (wrEn) begin
      // a write always wins over a pending hit
      armedQ <= armOnWrite;
      pulseQ <= 1'b0;
    end else begin
      armedQ <= armedQ && !stat.reached;
      pulseQ <= hitNow;
    end
  end

  assign matchPulse = pulseQ;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse); // R5

  AST_PULSE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(armedQ) && !$past(wrEn)); // R7

  AST_DISABLE_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && stat.newDisable |=> !armedQ && !matchPulse); // R3

  AST_PAST_TARGET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !stat.newInFuture |=> !armedQ); // R4

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-2:0] tickCount,
  output logic [DATA_W-1:0] rdData,
  output logic              matchPulse
);
  tcStrobe_t strobe;
  tcStatus_t stat;

  tick_cmp_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .stat       (stat),
    .strobe     (strobe),
    .matchPulse (matchPulse)
  );

  tick_cmp_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .tickCount (tickCount),
    .rdData    (rdData),
    .stat      (stat)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> rdData == {1'b1, {(DATA_W-1){1'b0}}} && !matchPulse); // R1

endmodule

// File: tb/tick_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module tick_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [62:0] tickCount = '0;
  logic [63:0] rdData;
  logic        matchPulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  logic [63:0] mReg;
  bit          mArmed;
  bit          mPulse;
  logic [62:0] cnt;
  int          pulseSeen;

  always #2.5 clk = ~clk;

  tick_cmp_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .tickCount(tickCount), .rdData(rdData), .matchPulse(matchPulse)
  );

  function automatic bit willArm(logic [63:0] d, logic [62:0] c);
    return !d[63] && (d[62:0] > c);
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, edge, update model, compare, advance counter
  task automatic cycle(bit we, logic [63:0] d, string tag);
    wrEn = we;
    wrData = d;
    tickCount = cnt;
    @(posedge clk);
    #1;
    if (we) begin
      mReg = d;
      mArmed = willArm(d, cnt);
      mPulse = 1'b0;
    end else if (mArmed && cnt >= mReg[62:0]) begin
      mPulse = 1'b1;
      mArmed = 1'b0;
    end else begin
      mPulse = 1'b0;
    end
    if (matchPulse) pulseSeen++;
    check64({tag, " pulse"}, {63'd0, matchPulse}, {63'd0, mPulse});
    check64({tag, " read"}, rdData, mReg);
    wrEn = 1'b0;
    cnt = cnt + 63'd1;
    tickCount = cnt;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cycle(1'b0, 64'd0, tag);
  endtask

  function automatic logic [63:0] tgt(logic [62:0] base, int off, bit dis);
    logic [62:0] v;
    v = base + 63'(off);
    return {dis, v};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd13579);
    cnt = 63'd100;
    tickCount = cnt;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check64("R1 reset read", rdData, 64'h8000_0000_0000_0000);
    check64("R1 reset pulse", {63'd0, matchPulse}, 64'd0);
    rstN = 1'b1;
    mReg = 64'h8000_0000_0000_0000;
    mArmed = 1'b0;
    mPulse = 1'b0;
    idle(3, "R1 idle after reset");

    // R5: target ahead fires once, then stays quiet
    pulseSeen = 0;
    cycle(1'b1, tgt(cnt, 5, 1'b0), "R5 arm");
    idle(12, "R5 run");
    check64("R5 pulse count", 64'(pulseSeen), 64'd1);

    // R4: target equal to count and behind it never fire
    pulseSeen = 0;
    cycle(1'b1, tgt(cnt, 0, 1'b0), "R4 equal");
    idle(6, "R4 equal run");
    cycle(1'b1, tgt(cnt, -3, 1'b0), "R4 behind");
    idle(6, "R4 behind run");
    check64("R4 pulse count", 64'(pulseSeen), 64'd0);
    // R4: one tick ahead does fire
    pulseSeen = 0;
    cycle(1'b1, tgt(cnt, 1, 1'b0), "R4 plus one");
    idle(4, "R4 plus one run");
    check64("R4 plus one count", 64'(pulseSeen), 64'd1);

    // R3: disabled write cancels an armed target
    pulseSeen = 0;
    cycle(1'b1, tgt(cnt, 4, 1'b0), "R3 arm");
    cycle(1'b1, tgt(cnt, 2, 1'b1), "R3 disable");
    idle(8, "R3 run");
    check64("R3 pulse count", 64'(pulseSeen), 64'd0);

    // R6: rewrite to a later target; old one passes silently
    pulseSeen = 0;
    cycle(1'b1, tgt(cnt, 3, 1'b0), "R6 first");
    cycle(1'b1, tgt(cnt, 9, 1'b0), "R6 later");
    idle(5, "R6 past old");
    check64("R6 no early pulse", 64'(pulseSeen), 64'd0);
    idle(6, "R6 reach new");
    check64("R6 one pulse", 64'(pulseSeen), 64'd1);
    // R6: rewrite to an earlier target
    pulseSeen = 0;
    cycle(1'b1, tgt(cnt, 10, 1'b0), "R6 far");
    cycle(1'b1, tgt(cnt, 2, 1'b0), "R6 near");
    idle(12, "R6 near run");
    check64("R6 near count", 64'(pulseSeen), 64'd1);

    // R7: write in the hit cycle wins
    pulseSeen = 0;
    cycle(1'b1, tgt(cnt, 2, 1'b0), "R7 arm");
    cycle(1'b0, 64'd0, "R7 wait");
    cycle(1'b1, tgt(cnt, 1, 1'b1), "R7 collide");
    idle(5, "R7 run");
    check64("R7 pulse count", 64'(pulseSeen), 64'd0);

    // R2: full-width readback of random values
    for (int i = 0; i < 8; i++)
      cycle(1'b1, {$urandom, $urandom}, "R2 readback");

    // mixed random: writes near the count, count jumps
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 6) == 0) cnt = cnt + 63'($urandom % 5);
      if (($urandom % 5) == 0)
        cycle(1'b1, tgt(cnt, int'($urandom % 10) - 3, ($urandom % 4) == 0),
              "R5 random");
      else
        cycle(1'b0, 64'd0, "R6 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule